// File: doc/BRIEF.md
# Masked Vector Lane Shuffle Unit

This block builds a result vector of up to 512 bits out of 128-bit lanes picked from two source vectors. An 8-bit selector says which lane of each source lands in each result lane. The low half of the result always comes from the first source and the high half from the second. The second source can be replaced by one of its own elements, copied into every element position, before any lane is picked.

The shuffled vector then passes through per-element masking at 32-bit or 64-bit granularity. A masked-off element either keeps the previous destination value (merge) or is cleared (zero). Bits above the active vector length are always cleared. The block treats all data as raw bits. It reports an illegal encoding when a floating-point shuffle asks for the 128-bit length.

The result is registered. An output strobe follows the input strobe by one clock. Between requests the output holds its last value.

Top module: `lane_shuffle_unit`

## Requirements
- R1: With 256-bit length, `sel[0]` picks lane 0 or lane 1 of `srcA` for result bits 127:0, and `sel[1]` picks lane 0 or lane 1 of the (possibly broadcast) second source for bits 255:128. Selector bits 7:2 have no effect.
- R2: With 512-bit length, the 2-bit fields `sel[1:0]` and `sel[3:2]` each name a lane of `srcA` for result lanes 0 and 1. The fields `sel[5:4]` and `sel[7:6]` each name a lane of the second source for result lanes 2 and 3. Lane index n means source bits 128n+127 down to 128n.
- R3: When both `bcast` and `srcBMem` are 1, the lowest element of `srcB` is copied into every element position of the second source before selection. That element is bits 31:0 when `elem64`=0 and bits 63:0 when `elem64`=1. If either flag is 0, `srcB` is used unchanged.
- R4: Mask bit j governs element j, which is bits 32j+31:32j when `elem64`=0 and bits 64j+63:64j when `elem64`=1. Mask bits beyond the active element count have no effect. When `maskEn`=0, every active element takes the shuffled value. When `maskEn`=1, an element whose mask bit is 1 takes the shuffled value.
- R5: With `maskEn`=1, an element whose mask bit is 0 takes the matching bits of `oldDest` when `zeroMode`=0, and is cleared to zero when `zeroMode`=1.
- R6: `lenCode`=2'b10 selects the 512-bit length, and every other code selects the 256-bit length. At the 256-bit length, `dest[511:256]` is zero.
- R7: When `isFloat`=1 and `lenCode`=2'b00, `illegal` is 1 and `dest` is all zero. Otherwise `illegal` is 0.
- R8: `outValid` is 1 in exactly the cycle after an accepted request (`inValid`=1). `dest` and `illegal` change only on a request and hold otherwise.
- R9: Reset (`rstN` low) clears `dest`, `illegal` and `outValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| srcA | input | 512 | First source vector |
| srcB | input | 512 | Second source vector |
| sel | input | 8 | Lane selector byte |
| lenCode | input | 2 | Vector length code (2'b10 = 512, else 256) |
| isFloat | input | 1 | Floating-point variant of the operation |
| elem64 | input | 1 | Element size 64 bits when 1, 32 bits when 0 |
| bcast | input | 1 | Broadcast request for the second source |
| srcBMem | input | 1 | Second source comes from memory |
| mask | input | 16 | Per-element write mask |
| maskEn | input | 1 | Masking enabled |
| zeroMode | input | 1 | Zero masked-off elements when 1, merge when 0 |
| oldDest | input | 512 | Previous destination value for merging |
| outValid | output | 1 | Result strobe, one cycle after request |
| dest | output | 512 | Result vector |
| illegal | output | 1 | Illegal encoding flag |

## Verification
The bench drives 256-bit requests whose upper selector bits are set. A design that decoded the full fields there would pull lanes 2 or 3 into the result. It runs 64-bit masks where element j must govern two 32-bit words. Wrong grouping shows up as merge or zero holes in odd words. Broadcast is tried with only one of its two flags raised; a design that ignored the memory flag would replicate data it should not. Further requests check that the upper half is cleared at 256-bit length, that the illegal floating-point code forces a zero result, and that the output holds when no request arrives.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int LANE_W    = 128;
  localparam int NUM_LANES = 4;
  localparam int IDX_W     = 2;

  typedef struct packed {
    logic                         load;
    logic                         wide;
    logic                         bcastAct;
    logic                         elem64;
    logic                         maskEn;
    logic                         zeroMode;
    logic                         illegal;
    logic [NUM_LANES-1:0]         laneFromB;
    logic [NUM_LANES-1:0]         laneLive;
    logic [NUM_LANES*IDX_W-1:0]   laneIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [7:0]   sel,
  input  logic [1:0]   lenCode,
  input  logic         isFloat,
  input  logic         elem64,
  input  logic         bcast,
  input  logic         srcBMem,
  input  logic         maskEn,
  input  logic         zeroMode,
  output ctrlStrobes_t strobes,
  output logic         outValid
);
  localparam logic [1:0] LEN_512 = 2'b10;
  localparam logic [1:0] LEN_128 = 2'b00;

  logic wide;
  assign wide = (lenCode == LEN_512);

  always_comb begin
    strobes          = '0;
    strobes.load     = inValid;
    strobes.wide     = wide;
    strobes.bcastAct = bcast && srcBMem;
    strobes.elem64   = elem64;
    strobes.maskEn   = maskEn;
    strobes.zeroMode = zeroMode;
    strobes.illegal  = isFloat && (lenCode == LEN_128);
    if (wide) begin
      strobes.laneIdx   = sel;
      strobes.laneFromB = 4'b1100;
      strobes.laneLive  = 4'b1111;
    end else begin
      strobes.laneIdx   = {4'b0000, 1'b0, sel[1], 1'b0, sel[0]};
      strobes.laneFromB = 4'b0010;
      strobes.laneLive  = 4'b0011;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/lsu_datapath.sv
module lsu_datapath
  import lsu_pkg::*;
#(
  parameter int VEC_W  = 512,
  parameter int WORD_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [VEC_W-1:0]     srcA,
  input  logic [VEC_W-1:0]     srcB,
  input  logic [VEC_W/WORD_W-1:0] mask,
  input  logic [VEC_W-1:0]     oldDest,
  output logic [VEC_W-1:0]     dest,
  output logic                 illegal
);
  localparam int NUM_WORDS = VEC_W / WORD_W;
  localparam int HALF_WORDS = NUM_WORDS / 2;

  logic [VEC_W-1:0] srcBEff;
  logic [VEC_W-1:0] shuffled;
  logic [VEC_W-1:0] nextDest;

  // broadcast stage on the second source
  for (genvar w = 0; w < NUM_WORDS; w++) begin : gBcast
    always_comb begin
      if (!strobes.bcastAct)
        srcBEff[w*WORD_W +: WORD_W] = srcB[w*WORD_W +: WORD_W];
      else if (strobes.elem64)
        srcBEff[w*WORD_W +: WORD_W] = srcB[(w%2)*WORD_W +: WORD_W];
      else
        srcBEff[w*WORD_W +: WORD_W] = srcB[WORD_W-1:0];
    end
  end

  // lane selection stage
  for (genvar k = 0; k < NUM_LANES; k++) begin : gLane
    logic [IDX_W-1:0] idx;
    logic [VEC_W-1:0] pick;
    assign idx  = strobes.laneIdx[k*IDX_W +: IDX_W];
    assign pick = strobes.laneFromB[k] ? srcBEff : srcA;
    always_comb begin
      if (strobes.laneLive[k])
        shuffled[k*LANE_W +: LANE_W] = pick[int'(idx)*LANE_W +: LANE_W];
      else
        shuffled[k*LANE_W +: LANE_W] = '0;
    end
  end

  // masking stage
  for (genvar w = 0; w < NUM_WORDS; w++) begin : gMask
    logic maskBit;
    logic active;
    assign maskBit = strobes.elem64 ? mask[w/2] : mask[w];
    assign active  = strobes.wide || (w < HALF_WORDS);
    always_comb begin
      if (!active)
        nextDest[w*WORD_W +: WORD_W] = '0;
      else if (!strobes.maskEn || maskBit)
        nextDest[w*WORD_W +: WORD_W] = shuffled[w*WORD_W +: WORD_W];
      else if (strobes.zeroMode)
        nextDest[w*WORD_W +: WORD_W] = '0;
      else
        nextDest[w*WORD_W +: WORD_W] = oldDest[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dest    <= '0;
      illegal <= 1'b0;
    end else if (strobes.load) begin
      illegal <= strobes.illegal;
      dest    <= strobes.illegal ? '0 : nextDest;
    end
  end
endmodule

// File: rtl/lane_shuffle_unit.sv
module lane_shuffle_unit
  import lsu_pkg::*;
#(
  parameter int VEC_W  = 512,
  parameter int WORD_W = 32,
  localparam int NUM_WORDS = VEC_W / WORD_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [VEC_W-1:0]     srcA,
  input  logic [VEC_W-1:0]     srcB,
  input  logic [7:0]           sel,
  input  logic [1:0]           lenCode,
  input  logic                 isFloat,
  input  logic                 elem64,
  input  logic                 bcast,
  input  logic                 srcBMem,
  input  logic [NUM_WORDS-1:0] mask,
  input  logic                 maskEn,
  input  logic                 zeroMode,
  input  logic [VEC_W-1:0]     oldDest,
  output logic                 outValid,
  output logic [VEC_W-1:0]     dest,
  output logic                 illegal
);
  ctrlStrobes_t strobes;

  lsu_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sel(sel), .lenCode(lenCode),
    .isFloat(isFloat), .elem64(elem64), .bcast(bcast), .srcBMem(srcBMem),
    .maskEn(maskEn), .zeroMode(zeroMode), .strobes(strobes), .outValid(outValid)
  );

  lsu_datapath #(.VEC_W(VEC_W), .WORD_W(WORD_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcA(srcA), .srcB(srcB),
    .mask(mask), .oldDest(oldDest), .dest(dest), .illegal(illegal)
  );
endmodule

// File: rtl/lsu_checker.sv
module lsu_checker (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [511:0] srcA,
  input logic [511:0] srcB,
  input logic [7:0]   sel,
  input logic [1:0]   lenCode,
  input logic         isFloat,
  input logic         bcast,
  input logic         maskEn,
  input logic         outValid,
  input logic [511:0] dest,
  input logic         illegal
);
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(dest) && $stable(illegal)));

  a_r7_illegal_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isFloat && lenCode == 2'b00) |=> (illegal && dest == '0));

  a_r6_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && lenCode != 2'b10) |=> (dest[511:256] == '0));

  a_r2_identity: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && lenCode == 2'b10 && !maskEn && !bcast && sel == 8'hE4)
      |=> (dest == {$past(srcB[511:256]), $past(srcA[255:0])}));
endmodule

bind lane_shuffle_unit lsu_checker i_lsu_checker (.*);

// File: tb/test_lane_shuffle_unit.sv
`timescale 1ns/1ps
module test_lane_shuffle_unit;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic [511:0] srcA, srcB, oldDest;
  logic [7:0]   sel;
  logic [1:0]   lenCode;
  logic         isFloat, elem64, bcast, srcBMem, maskEn, zeroMode;
  logic [15:0]  mask;
  logic         outValid, illegal;
  logic [511:0] dest;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lane_shuffle_unit i_lane_shuffle_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcA(srcA), .srcB(srcB),
    .sel(sel), .lenCode(lenCode), .isFloat(isFloat), .elem64(elem64),
    .bcast(bcast), .srcBMem(srcBMem), .mask(mask), .maskEn(maskEn),
    .zeroMode(zeroMode), .oldDest(oldDest), .outValid(outValid),
    .dest(dest), .illegal(illegal)
  );

  function automatic logic [511:0] model(
    input logic [511:0] a, input logic [511:0] b, input logic [7:0] s,
    input logic [1:0] len, input logic fp, input logic e64, input logic bc,
    input logic mem, input logic [15:0] m, input logic men, input logic zm,
    input logic [511:0] old);
    logic [511:0] bb, sh, r;
    bit big;
    big = (len == 2'b10);
    if (fp && len == 2'b00) return '0;
    for (int w = 0; w < 16; w++)
      bb[32*w +: 32] = (bc && mem) ? (e64 ? b[32*(w%2) +: 32] : b[31:0]) : b[32*w +: 32];
    sh = '0;
    if (big) begin
      sh[127:0]   = a[128*int'(s[1:0]) +: 128];
      sh[255:128] = a[128*int'(s[3:2]) +: 128];
      sh[383:256] = bb[128*int'(s[5:4]) +: 128];
      sh[511:384] = bb[128*int'(s[7:6]) +: 128];
    end else begin
      sh[127:0]   = a[128*int'(s[0]) +: 128];
      sh[255:128] = bb[128*int'(s[1]) +: 128];
    end
    for (int w = 0; w < 16; w++) begin
      logic mb;
      mb = e64 ? m[w/2] : m[w];
      if (!big && w >= 8)      r[32*w +: 32] = '0;
      else if (!men || mb)     r[32*w +: 32] = sh[32*w +: 32];
      else if (zm)             r[32*w +: 32] = '0;
      else                     r[32*w +: 32] = old[32*w +: 32];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [511:0] got, input logic [511:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic defaults();
    for (int w = 0; w < 16; w++) begin
      srcA[32*w +: 32]    = 32'hA0000000 | w;
      srcB[32*w +: 32]    = 32'hB0000000 | w;
      oldDest[32*w +: 32] = 32'hD0000000 | w;
    end
    sel = 8'h00; lenCode = 2'b10; isFloat = 0; elem64 = 0; bcast = 0;
    srcBMem = 0; mask = 16'hFFFF; maskEn = 0; zeroMode = 0;
  endtask

  // issue one request and check the registered result
  task automatic runOp(input string tag);
    logic [511:0] exp;
    logic expIll;
    exp    = model(srcA, srcB, sel, lenCode, isFloat, elem64, bcast, srcBMem, mask, maskEn, zeroMode, oldDest);
    expIll = isFloat && lenCode == 2'b00;
    @(negedge clk); inValid = 1'b1;
    @(negedge clk); inValid = 1'b0;
    check(tag, dest, exp);
    check({tag, " R7 flag"}, {511'd0, illegal}, {511'd0, expIll});
    check({tag, " R8 strobe"}, {511'd0, outValid}, 512'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [511:0] held;
    void'($urandom(32'h5EED));
    defaults();
    inValid = 0; rstN = 0;
    repeat (3) @(negedge clk);
    check("R9 reset dest", dest, '0);
    check("R9 reset flags", {510'd0, outValid, illegal}, '0);
    rstN = 1;

    // R1: 256-bit, upper selector bits set but ignored
    lenCode = 2'b01; sel = 8'hFD; runOp("R1 sel256 lo1 hi0");
    check("R1 lane0 literal", dest[127:0], {384'd0, srcA[255:128]});
    sel = 8'h02; runOp("R1 sel256 lo0 hi1");
    check("R1 lane1 literal", dest[255:128], {384'd0, srcB[255:128]});
    lenCode = 2'b11; sel = 8'hFF; runOp("R6 code11 is 256");

    // R2: 512-bit patterns
    lenCode = 2'b10;
    sel = 8'hE4; runOp("R2 identity");
    sel = 8'h1B; runOp("R2 reversed");
    check("R2 lane3 literal", dest[511:384], srcB[127:0]);
    sel = 8'hAA; runOp("R2 repeat lane2");

    // R3: broadcast
    sel = 8'h4E; bcast = 1; srcBMem = 1; elem64 = 0; runOp("R3 bcast32");
    check("R3 bcast32 word", dest[415:384], srcB[31:0]);
    elem64 = 1; runOp("R3 bcast64");
    srcBMem = 0; runOp("R3 no mem no bcast");
    bcast = 0; srcBMem = 1; runOp("R3 mem only no bcast");
    lenCode = 2'b01; bcast = 1; sel = 8'h03; runOp("R3 bcast 256");
    defaults();

    // R4 / R5: masking
    maskEn = 1; mask = 16'hA5C3; zeroMode = 0; runOp("R4 R5 merge32");
    zeroMode = 1; runOp("R5 zero32");
    elem64 = 1; mask = 16'hFF96; zeroMode = 0; runOp("R4 merge64 upper mask ignored");
    check("R4 elem64 word pair", dest[63:0], oldDest[63:0]);
    zeroMode = 1; runOp("R4 R5 zero64");
    elem64 = 0; lenCode = 2'b01; mask = 16'hFF0F; zeroMode = 0; runOp("R4 256 mask upper ignored");
    maskEn = 0; mask = 16'h0000; lenCode = 2'b10; runOp("R4 mask disabled");
    defaults();

    // R7: illegal encodings
    isFloat = 1; lenCode = 2'b00; runOp("R7 float 128");
    isFloat = 0; runOp("R7 int 128 legal");
    isFloat = 1; lenCode = 2'b10; runOp("R7 float 512 legal");
    defaults();

    // R8: hold without a request
    sel = 8'h39; runOp("R8 setup");
    held = dest;
    srcA = '1; sel = 8'h00;
    @(negedge clk); @(negedge clk);
    check("R8 hold dest", dest, held);
    check("R8 no strobe", {511'd0, outValid}, '0);

    // random mix covering R1..R7
    for (int n = 0; n < 300; n++) begin
      for (int w = 0; w < 16; w++) begin
        srcA[32*w +: 32]    = $urandom;
        srcB[32*w +: 32]    = $urandom;
        oldDest[32*w +: 32] = $urandom;
      end
      sel = 8'($urandom); lenCode = 2'($urandom); isFloat = 1'($urandom);
      elem64 = 1'($urandom); bcast = 1'($urandom); srcBMem = 1'($urandom);
      mask = 16'($urandom); maskEn = 1'($urandom); zeroMode = 1'($urandom);
      runOp("R2/R4 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule